// File: doc/BRIEF.md
# Bus Hold Arbitration Controller

This block lets an external bus master borrow a processor's local bus. The requester raises a level-sensitive hold request and keeps it high for as long as it owns the bus. The controller waits for a gap between the processor's own bus cycles. It then raises a hold acknowledge and, on the same clock edge, lowers one shared output enable. That enable gates the address, data, byte-enable, cycle-definition, lock and strobe pad drivers, so they float while the bus is granted away. When the request drops, the controller takes the bus back. The acknowledge falls and the pads are driven again on the same edge.

Reset has priority over everything else. While reset is high the hold request is ignored, and the bus is parked in an idle, driven state rather than a floating one. The non-maskable interrupt pin passes through a synchronizer. One rising edge seen while the bus is granted away is kept in a single pending flag. After the bus has been taken back, that flag is replayed to the core as a one-cycle pulse. Edges outside a hold period are not this block's concern: the core sees the pin directly.

All pins are plain control signals, and none carries a data stream. The block therefore has no valid/ready handshake and no back-pressure.

Top module: `bus_hold_arbiter`

## Requirements
- R1: During reset and on the first cycle after it, `hold_ack` is 0, `bus_oe` is 1 and `nmi_pulse` is 0, whatever the other inputs are. `hold_ack` never rises on the edge that follows a cycle in which reset was high.
- R2: With the bus owned by the processor, `hold_ack` rises one cycle after a clock edge that samples `hold_req`=1 and `cycle_busy`=0. It never rises otherwise.
- R3: While `cycle_busy` is 1, a pending hold request is not granted: `hold_ack` stays 0.
- R4: `bus_oe` is 1 exactly when `hold_ack` is 0. The pads are never driven while the bus is granted away.
- R5: When an edge samples `hold_req`=0 while `hold_ack` is 1, `hold_ack` falls to 0 and `bus_oe` rises to 1 after that same edge.
- R6: While `hold_req` stays 1, `hold_ack` stays 1. `cycle_busy` has no effect during a grant.
- R7: Reset asserted during a grant drops `hold_ack`, re-enables the pads after the next edge and discards any pending NMI, so no pulse follows.
- R8: An NMI rising edge is counted after NMI_SYNC_STAGES+1 edges. If it is counted while `hold_ack` is 1 (the release edge included), `nmi_pulse` is 1 for exactly one cycle, on the cycle after `hold_ack` falls.
- R9: Two or more NMI edges in one hold period give one pulse only.
- R10: NMI edges counted while `hold_ack` is 0 give no pulse, not even after a later grant and release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high, overrides hold |
| hold_req | input | 1 | Level-sensitive bus request from the other master |
| cycle_busy | input | 1 | Processor bus cycle in progress; grant waits for 0 |
| nmi_in | input | 1 | Non-maskable interrupt pin, asynchronous |
| hold_ack | output | 1 | Bus granted to the other master |
| bus_oe | output | 1 | Shared enable for the address, data and cycle pads |
| nmi_pulse | output | 1 | One-cycle replay of an NMI stored during hold |

## Verification
The checker checks every cycle that the pad enable and the acknowledge are complementary. It also checks that a grant only follows a sampled request at a cycle boundary, that release and retention follow the request level, that reset leaves the bus parked and driven, and that the replay pulse is a single cycle. Only the bench's scenarios can show whether an NMI edge is stored or dropped, and that takes a full hold period. They cover the exact replay cycle after release, merging of repeated edges, edges outside hold, and a pending event discarded by reset. A reference model also follows long random sequences.

// File: rtl/bh_pkg.sv
package bh_pkg;
  typedef enum logic [0:0] {
    BUS_OWNED   = 1'b0,
    BUS_GRANTED = 1'b1
  } bus_own_e;
endpackage

// File: rtl/bh_nmi_edge.sv
// Synchronizes the interrupt pin and flags one cycle per rising level.
module bh_nmi_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin,
  output logic rise
);
  localparam int LAST = STAGES - 1;

  logic [STAGES-1:0] sync_q;
  logic              seen_q;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_sync
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) sync_q[s] <= 1'b0;
          else     sync_q[s] <= pin;
        end
      end else begin : g_chain
        always_ff @(posedge clk) begin
          if (rst) sync_q[s] <= 1'b0;
          else     sync_q[s] <= sync_q[s-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) seen_q <= 1'b0;
    else     seen_q <= sync_q[LAST];
  end

  assign rise = sync_q[LAST] & ~seen_q;
endmodule

// File: rtl/bh_grant_fsm.sv
// Owns the bus mastership decision and the pad enable.
module bh_grant_fsm
  import bh_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic hold_req,
  input  logic cycle_busy,
  output logic granted,
  output logic pads_on
);
  bus_own_e state_q, state_d;
  logic     oe_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      BUS_OWNED:   if (hold_req && !cycle_busy) state_d = BUS_GRANTED;
      BUS_GRANTED: if (!hold_req)               state_d = BUS_OWNED;
      default:                                  state_d = BUS_OWNED;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= BUS_OWNED;
      oe_q    <= 1'b1;
    end else begin
      state_q <= state_d;
      oe_q    <= (state_d == BUS_OWNED);
    end
  end

  assign granted = (state_q == BUS_GRANTED);
  assign pads_on = oe_q;
endmodule

// File: rtl/bh_nmi_hold_latch.sv
// Keeps at most one interrupt edge seen during a grant and replays it later.
module bh_nmi_hold_latch (
  input  logic clk,
  input  logic rst,
  input  logic granted,
  input  logic nmi_rise,
  output logic nmi_pulse
);
  logic pend_q;
  logic pulse_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q  <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      pulse_q <= pend_q & ~granted;
      if (granted && nmi_rise)  pend_q <= 1'b1;
      else if (pend_q && !granted) pend_q <= 1'b0;
    end
  end

  assign nmi_pulse = pulse_q;
endmodule

// File: rtl/bus_hold_arbiter.sv
module bus_hold_arbiter #(
  parameter int NMI_SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic hold_req,
  input  logic cycle_busy,
  input  logic nmi_in,
  output logic hold_ack,
  output logic bus_oe,
  output logic nmi_pulse
);
  localparam int SYNC_N = (NMI_SYNC_STAGES < 1) ? 1 : NMI_SYNC_STAGES;

  logic granted;
  logic pads_on;
  logic nmi_rise;

  bh_grant_fsm u_fsm (
    .clk        (clk),
    .rst        (rst),
    .hold_req   (hold_req),
    .cycle_busy (cycle_busy),
    .granted    (granted),
    .pads_on    (pads_on)
  );

  bh_nmi_edge #(.STAGES(SYNC_N)) u_edge (
    .clk  (clk),
    .rst  (rst),
    .pin  (nmi_in),
    .rise (nmi_rise)
  );

  bh_nmi_hold_latch u_latch (
    .clk       (clk),
    .rst       (rst),
    .granted   (granted),
    .nmi_rise  (nmi_rise),
    .nmi_pulse (nmi_pulse)
  );

  assign hold_ack = granted;
  assign bus_oe   = pads_on;
endmodule

// File: rtl/bh_checker.sv
module bh_checker (
  input logic clk,
  input logic rst,
  input logic hold_req,
  input logic cycle_busy,
  input logic hold_ack,
  input logic bus_oe,
  input logic nmi_pulse
);
  logic rst_d;
  always_ff @(posedge clk) rst_d <= rst;

  // R1 / R7: the cycle after a reset edge shows a parked, driven bus
  always @(posedge clk) begin
    if (rst_d === 1'b1) begin
      assert_reset_parks_R7: assert (!hold_ack && bus_oe && !nmi_pulse);
    end
  end

  assert_no_ack_after_reset_R1: assert property (@(posedge clk) disable iff (rst)
    $rose(hold_ack) |-> !$past(rst));

  assert_grant_at_boundary_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(hold_ack) |-> ($past(hold_req) && !$past(cycle_busy)));

  assert_float_when_ack_R4: assert property (@(posedge clk) disable iff (rst)
    hold_ack |-> !bus_oe);

  assert_drive_when_owned_R4: assert property (@(posedge clk) disable iff (rst)
    !hold_ack |-> bus_oe);

  assert_release_R5: assert property (@(posedge clk) disable iff (rst)
    (hold_ack && !hold_req) |=> (!hold_ack && bus_oe));

  assert_keep_grant_R6: assert property (@(posedge clk) disable iff (rst)
    (hold_ack && hold_req) |=> hold_ack);

  assert_single_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    nmi_pulse |=> !nmi_pulse);

  assert_pulse_after_release_R8: assert property (@(posedge clk) disable iff (rst)
    nmi_pulse |-> !$past(hold_ack));
endmodule

bind bus_hold_arbiter bh_checker u_chk (
  .clk        (clk),
  .rst        (rst),
  .hold_req   (hold_req),
  .cycle_busy (cycle_busy),
  .hold_ack   (hold_ack),
  .bus_oe     (bus_oe),
  .nmi_pulse  (nmi_pulse)
);

// File: tb/bus_hold_arbiter_test.sv
module bus_hold_arbiter_test;
  localparam int CLK_PERIOD = 10;
  localparam int SYNC       = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic hold_req = 1'b0;
  logic cycle_busy = 1'b0;
  logic nmi_in = 1'b0;
  logic hold_ack, bus_oe, nmi_pulse;

  int checks = 0;
  int errors = 0;
  int pulse_count = 0;

  logic            m_ack, m_oe, m_pend, m_pulse, m_last;
  logic [SYNC-1:0] m_sync;

  always #(CLK_PERIOD/2) clk = ~clk;

  bus_hold_arbiter #(.NMI_SYNC_STAGES(SYNC)) uut (
    .clk(clk), .rst(rst), .hold_req(hold_req), .cycle_busy(cycle_busy),
    .nmi_in(nmi_in), .hold_ack(hold_ack), .bus_oe(bus_oe), .nmi_pulse(nmi_pulse)
  );

  function automatic logic next_ack(logic r, logic ack, logic h, logic b);
    if (r) return 1'b0;
    return ack ? h : (h && !b);
  endfunction

  task automatic check(input string tag, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0b expected=%0b at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic check_int(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic model_edge(input logic r, input logic h, input logic b, input logic n);
    logic edge_now;
    if (r) begin
      m_ack = 1'b0; m_oe = 1'b1; m_pend = 1'b0; m_pulse = 1'b0;
      m_sync = '0; m_last = 1'b0;
    end else begin
      edge_now = m_sync[SYNC-1] & ~m_last;
      m_last   = m_sync[SYNC-1];
      m_sync   = {m_sync[SYNC-2:0], n};
      m_pulse  = m_pend & ~m_ack;
      if (m_ack && edge_now)      m_pend = 1'b1;
      else if (m_pend && !m_ack)  m_pend = 1'b0;
      m_ack = next_ack(r, m_ack, h, b);
      m_oe  = !m_ack;
    end
  endtask

  // drive at a falling edge, let the rising edge act, compare at the next falling edge
  task automatic step(input logic r, input logic h, input logic b, input logic n);
    rst = r; hold_req = h; cycle_busy = b; nmi_in = n;
    @(posedge clk);
    model_edge(r, h, b, n);
    @(negedge clk);
    check(r ? "R1" : "R2", "hold_ack vs model", hold_ack, m_ack);
    check("R4", "bus_oe vs model", bus_oe, m_oe);
    check("R8", "nmi_pulse vs model", nmi_pulse, m_pulse);
    if (nmi_pulse === 1'b1) pulse_count++;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired at %0t", $time);
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic h;
    void'($urandom(32'h5eed_0b17));
    @(negedge clk);
    // R1, R7: reset with hold asserted parks the bus driven
    for (int i = 0; i < 3; i++) step(1, 1, 0, 0);
    check("R7", "ack under reset with hold", hold_ack, 1'b0);
    check("R1", "oe under reset", bus_oe, 1'b1);
    check("R1", "pulse under reset", nmi_pulse, 1'b0);

    // R3: busy cycle blocks the grant
    for (int i = 0; i < 3; i++) begin
      step(0, 1, 1, 0);
      check("R3", "no grant while busy", hold_ack, 1'b0);
    end
    step(0, 1, 0, 0);
    check("R2", "grant at boundary", hold_ack, 1'b1);
    check("R4", "pads float on grant", bus_oe, 1'b0);

    // R6: busy toggling during grant has no effect
    for (int i = 0; i < 4; i++) begin
      step(0, 1, i[0], 0);
      check("R6", "grant kept", hold_ack, 1'b1);
    end

    // R8, R9: two NMI edges within one hold period
    pulse_count = 0;
    step(0, 1, 0, 1);
    for (int i = 0; i < 4; i++) step(0, 1, 0, 0);
    step(0, 1, 0, 1);
    for (int i = 0; i < 4; i++) step(0, 1, 0, 0);
    check_int("R8", "no pulse while granted", pulse_count, 0);
    step(0, 0, 0, 0);
    check("R5", "ack drops on release", hold_ack, 1'b0);
    check("R5", "pads driven on release", bus_oe, 1'b1);
    check("R8", "no pulse on release cycle", nmi_pulse, 1'b0);
    step(0, 0, 0, 0);
    check("R8", "pulse one cycle after release", nmi_pulse, 1'b1);
    step(0, 0, 0, 0);
    check("R8", "pulse is single cycle", nmi_pulse, 1'b0);
    for (int i = 0; i < 4; i++) step(0, 0, 0, 0);
    check_int("R9", "one pulse per hold", pulse_count, 1);

    // R10: edge while owned, then a clean grant and release
    pulse_count = 0;
    step(0, 0, 0, 1);
    for (int i = 0; i < 4; i++) step(0, 0, 0, 0);
    for (int i = 0; i < 3; i++) step(0, 1, 0, 0);
    for (int i = 0; i < 4; i++) step(0, 0, 0, 0);
    check_int("R10", "no pulse for edge outside hold", pulse_count, 0);

    // R7: reset during grant discards the pending NMI
    pulse_count = 0;
    for (int i = 0; i < 2; i++) step(0, 1, 0, 0);
    step(0, 1, 0, 1);
    for (int i = 0; i < 4; i++) step(0, 1, 0, 0);
    step(1, 1, 0, 0);
    check("R7", "reset drops ack", hold_ack, 1'b0);
    check("R7", "reset drives pads", bus_oe, 1'b1);
    for (int i = 0; i < 4; i++) step(0, 0, 0, 0);
    check_int("R7", "pending cleared by reset", pulse_count, 0);

    // random traffic against the model
    h = 1'b0;
    for (int i = 0; i < 6000; i++) begin
      if ($urandom_range(7) == 0) h = ~h;
      step(($urandom_range(399) == 0), h, $urandom_range(1), ($urandom_range(5) == 0) ? ~nmi_in : nmi_in);
    end

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule